// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-purpose register store of a 32-bit processor core that runs in several privilege modes. Software always sees sixteen logical registers, indices 0 to 15. Some of those indices are backed by a different physical word depending on the mode the core is in. A mode switch therefore swaps the stack pointer, the link register and, for the fast-interrupt mode, five working registers, without copying any data. Index 15 is the program counter. It is also reachable through a dedicated port, so the fetch logic can advance it. A general write to index 15 is a branch.

The block also keeps one saved-status word for each exception mode. The core uses it to park the current status word on exception entry. The current status word lives in the exception sequencer, which supplies its 5-bit mode field on the `mode` input.

The file has two combinational read ports and one write port that takes effect at the clock edge. A write in the same cycle is forwarded to the read ports, so a single-edge pipeline sees the new value without waiting a cycle. An override input lets the sequencer aim the write port and the saved-status write at a different mode's bank, for example to fill in a target mode's link register before switching to that mode.

Top module: `mode_bank_rf`

## Requirements
- R1: After reset, every register, the program counter and every saved-status word read as zero.
- R2: Indices 0 to 7 each have a single physical copy that is read and written identically in every mode.
- R3: Indices 8 to 12 have a separate copy used only in fast-interrupt mode (mode 10001). All other modes share the other copy.
- R4: Indices 13 and 14 have six copies: one shared by user (10000) and system (11111), and one each for fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011).
- R5: A mode value not listed in R4 selects the user bank for registers and for saved status.
- R6: Reads are combinational. When the write port targets the same physical register as a read port in the same cycle, that read port returns the write data.
- R7: Index 15 is a single program-counter register. A general write to index 15 raises `branch` in that cycle and loads the counter at the edge, taking priority over the counter port.
- R8: `pc_ld` loads `pc_next` into the counter at the edge when no general write to index 15 is present. Otherwise the counter holds its value.
- R9: Each of the five exception modes has its own saved-status word, read on `ss_rdata` and written by `ss_wr` for the selected mode. In user, system or unlisted modes it reads zero, and writes there change no word.
- R10: With `ovr_en` high, the register write and the saved-status write use the bank of `ovr_mode` instead of `mode`. Reads still use `mode`, and a read is forwarded only when it maps to the same physical register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 5 | Current processor mode field |
| ra_idx | input | 4 | Read port A logical index |
| ra_data | output | DW | Read port A data |
| rb_idx | input | 4 | Read port B logical index |
| rb_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write logical index |
| wr_data | input | DW | Register write data |
| ovr_en | input | 1 | Use `ovr_mode` for writes |
| ovr_mode | input | 5 | Target mode for overridden writes |
| pc_ld | input | 1 | Program-counter load from fetch |
| pc_next | input | DW | Program-counter load value |
| pc | output | DW | Current program counter |
| branch | output | 1 | A general write to index 15 is in progress |
| ss_wr | input | 1 | Saved-status write enable |
| ss_wdata | input | DW | Saved-status write data |
| ss_rdata | output | DW | Saved-status word of the current mode |

## Verification
The bench writes a distinct value to every index in every mode, including one unlisted mode value. It then reads the whole file back in every mode. A mapping error shows up as a value leaking between banks, for example a fast-interrupt write visible in user mode, or system mode holding its own stack pointer. The bench also drives same-cycle write and read pairs, with and without the override. A file without forwarding returns the old word, and one that forwards by logical index returns a value belonging to another mode. The program counter is tested with a branch and a fetch load in the same cycle, then with a fetch load alone, then idle. A wrong priority or a counter that drifts when idle shows in `pc`. Saved-status writes are attempted in every mode, so a user-mode write that lands in a real word is caught.

// File: rtl/mode_bank_rf.sv
module mode_bank_rf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode,
  input  logic [3:0]    ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          ovr_en,
  input  logic [4:0]    ovr_mode,
  input  logic          pc_ld,
  input  logic [DW-1:0] pc_next,
  output logic [DW-1:0] pc,
  output logic          branch,
  input  logic          ss_wr,
  input  logic [DW-1:0] ss_wdata,
  output logic [DW-1:0] ss_rdata
);
  localparam int NPHYS = 31;
  localparam int SW = $clog2(NPHYS);
  localparam int NSS = 5;
  localparam int PCS = NPHYS - 1;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   bank_of = 3'd1;
      M_IRQ:   bank_of = 3'd2;
      M_SVC:   bank_of = 3'd3;
      M_ABT:   bank_of = 3'd4;
      M_UND:   bank_of = 3'd5;
      default: bank_of = 3'd0;
    endcase
  endfunction

  function automatic logic [SW-1:0] slot(input logic [2:0] b, input logic [3:0] i);
    if (i < 4'd8)
      slot = SW'(i);
    else if (i < 4'd13)
      slot = (b == 3'd1) ? SW'(i) + SW'(5) : SW'(i);
    else if (i < 4'd15)
      slot = SW'(18) + SW'({b, 1'b0}) + SW'(i - 4'd13);
    else
      slot = SW'(PCS);
  endfunction

  logic [DW-1:0] rf [NPHYS];
  logic [DW-1:0] ss_q [NSS];

  logic [2:0] cbank, wbank;
  logic [SW-1:0] aslot, bslot, wslot;

  assign cbank = bank_of(mode);
  assign wbank = ovr_en ? bank_of(ovr_mode) : cbank;
  assign aslot = slot(cbank, ra_idx);
  assign bslot = slot(cbank, rb_idx);
  assign wslot = slot(wbank, wr_idx);

  assign ra_data = (wr_en && wslot == aslot) ? wr_data : rf[aslot];
  assign rb_data = (wr_en && wslot == bslot) ? wr_data : rf[bslot];
  assign pc      = rf[PCS];
  assign branch  = wr_en && wr_idx == 4'd15;

  assign ss_rdata = (cbank == 3'd0) ? '0 :
                    (ss_wr && wbank == cbank) ? ss_wdata : ss_q[cbank - 3'd1];

  for (genvar k = 0; k < NPHYS; k++) begin : g_rf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rf[k] <= '0;
      else if (wr_en && wslot == SW'(k))
        rf[k] <= wr_data;
      else if (k == PCS && pc_ld)
        rf[k] <= pc_next;
    end
  end

  for (genvar j = 0; j < NSS; j++) begin : g_ss
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ss_q[j] <= '0;
      else if (ss_wr && wbank == 3'(j + 1))
        ss_q[j] <= ss_wdata;
    end
  end

  assert_pc_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |=> pc == $past(wr_data));

  assert_pc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && !(wr_en && wr_idx == 4'd15)) |=> pc == $past(pc_next));

  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_ld && !(wr_en && wr_idx == 4'd15)) |=> $stable(pc));

  assert_fwd_same_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ovr_en && ra_idx == wr_idx) |-> ra_data == wr_data);

  assert_ss_user_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_FIQ && mode != M_IRQ && mode != M_SVC && mode != M_ABT && mode != M_UND)
      |-> ss_rdata == '0);

endmodule

// File: tb/mode_bank_rf_test.sv
module mode_bank_rf_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] mode = 5'b10000, ovr_mode = 5'b10000;
  logic [3:0] ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [31:0] ra_data, rb_data, wr_data = 0, pc_next = 0, pc, ss_wdata = 0, ss_rdata;
  logic wr_en = 0, ovr_en = 0, pc_ld = 0, branch, ss_wr = 0;
  int total = 0, bad = 0;

  localparam logic [4:0] MS [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                    5'b10111, 5'b11011, 5'b11111, 5'b00000};
  logic [31:0] mdl [31];
  logic [31:0] ssm [6];

  always #4 clk = ~clk;

  mode_bank_rf uut (.clk, .rst_n, .mode, .ra_idx, .ra_data, .rb_idx, .rb_data,
    .wr_en, .wr_idx, .wr_data, .ovr_en, .ovr_mode, .pc_ld, .pc_next, .pc, .branch,
    .ss_wr, .ss_wdata, .ss_rdata);

  function automatic int bk(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic int phys(input logic [4:0] m, input int i);
    if (i < 8) return i;
    if (i < 13) return (bk(m) == 1) ? i + 5 : i;
    if (i < 15) return 18 + 2 * bk(m) + (i - 13);
    return 30;
  endfunction

  function automatic string tag(input int mi, input int i);
    if (mi == 7) return "R5";
    if (i < 8) return "R2";
    if (i < 13) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] m, input int i, input logic [31:0] d);
    @(negedge clk);
    mode = m; wr_en = 1; wr_idx = 4'(i); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    mdl[phys(m, i)] = d;
  endtask

  task automatic sweep_check();
    for (int mi = 0; mi < 8; mi++)
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        mode = MS[mi]; ra_idx = 4'(i); rb_idx = 4'(14 - i);
        #2;
        chk(tag(mi, i), ra_data, mdl[phys(MS[mi], i)]);
        chk(tag(mi, 14 - i), rb_data, mdl[phys(MS[mi], 14 - i)]);
      end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 31; k++) mdl[k] = 0;
    for (int k = 0; k < 6; k++) ssm[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: everything zero after reset
    for (int mi = 0; mi < 8; mi++)
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        mode = MS[mi]; ra_idx = 4'(i); rb_idx = 4'(15 - i);
        #2;
        chk("R1", ra_data, 0);
        chk("R1", rb_data, 0);
        chk("R1", ss_rdata, 0);
      end
    chk("R1", pc, 0);

    // R2 R3 R4 R5: distinct value per index per mode, read back everywhere
    for (int mi = 0; mi < 8; mi++)
      for (int i = 0; i < 15; i++)
        wr(MS[mi], i, {8'(mi), 8'(i), 16'h5A00 + 16'(mi * 16 + i)});
    sweep_check();

    // R6: same-cycle forwarding in supervisor mode
    @(negedge clk);
    mode = 5'b10011; wr_en = 1; wr_idx = 4'd5; wr_data = 32'hF00D_0005;
    ra_idx = 4'd5; rb_idx = 4'd13;
    #2;
    chk("R6", ra_data, 32'hF00D_0005);
    chk("R6", rb_data, mdl[phys(5'b10011, 13)]);
    @(negedge clk);
    wr_en = 0; mdl[5] = 32'hF00D_0005;
    wr_idx = 4'd13; wr_data = 32'hF00D_0013;
    wr_en = 1; rb_idx = 4'd13;
    #2;
    chk("R6", rb_data, 32'hF00D_0013);
    @(negedge clk);
    wr_en = 0; mdl[phys(5'b10011, 13)] = 32'hF00D_0013;

    // R10: override write into supervisor link register from user mode
    @(negedge clk);
    mode = 5'b10000; ovr_en = 1; ovr_mode = 5'b10011;
    wr_en = 1; wr_idx = 4'd14; wr_data = 32'hABCD_0014; ra_idx = 4'd14;
    #2;
    chk("R10", ra_data, mdl[phys(5'b10000, 14)]);
    @(negedge clk);
    wr_en = 0; mdl[phys(5'b10011, 14)] = 32'hABCD_0014;
    // R10: override into fast-interrupt bank, index 10
    wr_en = 1; ovr_mode = 5'b10001; wr_idx = 4'd10; wr_data = 32'hABCD_0010; ra_idx = 4'd10;
    #2;
    chk("R10", ra_data, mdl[10]);
    @(negedge clk);
    wr_en = 0; ovr_en = 0; mdl[15] = 32'hABCD_0010;
    // R10: override into a shared index forwards
    @(negedge clk);
    ovr_en = 1; ovr_mode = 5'b10010; wr_en = 1; wr_idx = 4'd2; wr_data = 32'hABCD_0002; ra_idx = 4'd2;
    #2;
    chk("R10", ra_data, 32'hABCD_0002);
    @(negedge clk);
    wr_en = 0; ovr_en = 0; mdl[2] = 32'hABCD_0002;
    sweep_check();

    // R9: saved-status writes in every mode
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk);
      mode = MS[mi]; ss_wr = 1; ss_wdata = 32'hC0DE_0000 + 32'(mi);
      @(negedge clk);
      ss_wr = 0;
      if (bk(MS[mi]) != 0) ssm[bk(MS[mi])] = 32'hC0DE_0000 + 32'(mi);
    end
    // R10: override saved-status write into abort from user mode
    @(negedge clk);
    mode = 5'b10000; ovr_en = 1; ovr_mode = 5'b10111; ss_wr = 1; ss_wdata = 32'h5AFE_0004;
    #2;
    chk("R10", ss_rdata, 0);
    @(negedge clk);
    ss_wr = 0; ovr_en = 0; ssm[4] = 32'h5AFE_0004;
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk);
      mode = MS[mi];
      #2;
      chk(mi == 7 ? "R5" : "R9", ss_rdata, ssm[bk(MS[mi])] & {32{bk(MS[mi]) != 0}});
    end

    // R7: branch beats counter port
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd15; wr_data = 32'h0000_0100; pc_ld = 1; pc_next = 32'h44; ra_idx = 4'd15;
    #2;
    chk("R7", {31'd0, branch}, 1);
    chk("R7", ra_data, 32'h100);
    @(negedge clk);
    wr_en = 0; pc_ld = 0;
    #2;
    chk("R7", pc, 32'h100);
    chk("R7", ra_data, 32'h100);
    chk("R7", {31'd0, branch}, 0);

    // R8: counter port load, then hold
    @(negedge clk);
    pc_ld = 1; pc_next = 32'h104;
    #2;
    chk("R8", {31'd0, branch}, 0);
    chk("R8", pc, 32'h100);
    @(negedge clk);
    pc_ld = 0;
    #2;
    chk("R8", pc, 32'h104);
    @(negedge clk);
    #2;
    chk("R8", pc, 32'h104);
    rb_idx = 4'd15; mode = 5'b10001;
    #1;
    chk("R8", rb_data, 32'h104);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule